// File: doc/BRIEF.md
# Segmented Serial Shift Register with Bidirectional Segment Taps

The block holds two independent serial shift registers. Each one has its own clock, its own write enable and its own synchronous clear. A register is 64 stages long by default and is split into four equal segments of 16 stages. Every segment boundary has a tap. While write enable is low, the segments are chained into one long shift path. The four taps then report the last stage of each segment, and their output enables are asserted.

While write enable is high, every tap output enable drops. The three inner taps then act as inputs. On each rising edge, the value present on an inner tap enters the first stage of the segment that follows it, in place of the bit from the previous segment. The serial input always feeds stage 1. Four streams can therefore fill the whole register in one segment length of clocks, which is 16 clocks by default. The data can then be read back serially through the last tap with write enable low.

Each bidirectional tap is split into three signals: an output value, an active-high output enable and an input value. A pad or bus driver outside the block combines them. The clear only sets every stage to zero so that a simulation starts from a known state. The register itself needs no reset.

Top module: `seg_tap_shreg_dual`

## Requirements
- R1: On every rising edge of a channel clock with clear low, the serial input enters stage 1 of that channel, whatever the level of write enable.
- R2: With write enable low at a rising edge, every stage n>1 takes the old value of stage n-1, across segment boundaries as well. Tap output bit k (k=0..3) always carries stage 16·(k+1).
- R3: With write enable high at a rising edge, stages 17, 33 and 49 take tap input bits 0, 1 and 2 respectively. All other stages n>1 still take stage n-1.
- R4: All four tap output-enable bits of a channel equal the inverse of that channel's write enable, in the same cycle, without waiting for a clock edge.
- R5: The last tap (tap output bit 3, stage 64) is never loaded from outside the register. While write enable is high it keeps reporting stage 64 with its enable low.
- R6: After 16 rising edges with write enable high, a following serial read with write enable low presents on tap output bit 3, in order: the stream on tap input 2, then the stream on tap input 1, then the stream on tap input 0, then the serial-input stream. Each stream appears oldest bit first.
- R7: A rising edge with clear high sets all 64 stages of that channel to 0.
- R8: The two channels are independent. While one channel's clock is idle, its tap outputs and stored contents do not change, whatever the other channel or that channel's data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Channel A clock, rising edge active |
| clr_a | input | 1 | Channel A synchronous clear, active high |
| wen_a | input | 1 | Channel A write enable: inner taps become inputs, all tap outputs disabled |
| sin_a | input | 1 | Channel A serial data into stage 1 |
| tap_in_a | input | 3 | Channel A tap inputs; bit k feeds stage 16·(k+1)+1 |
| tap_out_a | output | 4 | Channel A tap values; bit k is stage 16·(k+1) |
| tap_oe_a | output | 4 | Channel A tap output enables, active high |
| clk_b | input | 1 | Channel B clock, rising edge active |
| clr_b | input | 1 | Channel B synchronous clear, active high |
| wen_b | input | 1 | Channel B write enable |
| sin_b | input | 1 | Channel B serial data into stage 1 |
| tap_in_b | input | 3 | Channel B tap inputs |
| tap_out_b | output | 4 | Channel B tap values |
| tap_oe_b | output | 4 | Channel B tap output enables |

## Verification
At every rising edge, stage 1 takes the serial input while stages 17, 33 and 49 may take tap inputs. The serial entry and the parallel tap load therefore fall in the same cycle whenever write enable is high. The bench drives independent streams on all four data sources during a 16-clock load, then toggles write enable at random from cycle to cycle on both channels. A behavioural bit-array model checks every tap on every clock. The serial read-back order after the parallel load shows whether both paths took the right bit in the same edge.

// File: rtl/seg_tap_pkg.sv
`timescale 1ns/1ps
package seg_tap_pkg;
  localparam int unsigned SEG_LEN_DEF = 16;
  localparam int unsigned SEG_CNT_DEF = 4;
endpackage

// File: rtl/seg_tap_segment.sv
`timescale 1ns/1ps
module seg_tap_segment #(
  parameter int unsigned LEN = seg_tap_pkg::SEG_LEN_DEF
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           din,
  output logic [LEN-1:0] q
);
  // q[0] is the first stage of the segment, q[LEN-1] the last
  always_ff @(posedge clk) begin
    if (clr) q <= '0;
    else     q <= {q[LEN-2:0], din};
  end
endmodule

// File: rtl/seg_tap_channel.sv
`timescale 1ns/1ps
module seg_tap_channel #(
  parameter int unsigned SEG_LEN = seg_tap_pkg::SEG_LEN_DEF,
  parameter int unsigned SEG_CNT = seg_tap_pkg::SEG_CNT_DEF
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               wen,
  input  logic               sin,
  input  logic [SEG_CNT-2:0] tap_in,
  output logic [SEG_CNT-1:0] tap_out,
  output logic [SEG_CNT-1:0] tap_oe
);
  logic [SEG_CNT-1:0][SEG_LEN-1:0] seg_q;
  logic [SEG_CNT-1:0]              seg_in;

  for (genvar k = 0; k < SEG_CNT; k++) begin : g_seg
    if (k == 0) begin : g_head
      assign seg_in[k] = sin;
    end else begin : g_link
      // boundary source: tap input while writing, previous segment otherwise
      assign seg_in[k] = wen ? tap_in[k-1] : seg_q[k-1][SEG_LEN-1];
    end

    seg_tap_segment #(.LEN(SEG_LEN)) u_seg (
      .clk (clk),
      .clr (clr),
      .din (seg_in[k]),
      .q   (seg_q[k])
    );

    assign tap_out[k] = seg_q[k][SEG_LEN-1];
    assign tap_oe[k]  = ~wen;
  end
endmodule

// File: rtl/seg_tap_shreg_dual.sv
`timescale 1ns/1ps
module seg_tap_shreg_dual #(
  parameter int unsigned SEG_LEN = seg_tap_pkg::SEG_LEN_DEF,
  parameter int unsigned SEG_CNT = seg_tap_pkg::SEG_CNT_DEF
) (
  input  logic               clk_a,
  input  logic               clr_a,
  input  logic               wen_a,
  input  logic               sin_a,
  input  logic [SEG_CNT-2:0] tap_in_a,
  output logic [SEG_CNT-1:0] tap_out_a,
  output logic [SEG_CNT-1:0] tap_oe_a,
  input  logic               clk_b,
  input  logic               clr_b,
  input  logic               wen_b,
  input  logic               sin_b,
  input  logic [SEG_CNT-2:0] tap_in_b,
  output logic [SEG_CNT-1:0] tap_out_b,
  output logic [SEG_CNT-1:0] tap_oe_b
);
  seg_tap_channel #(.SEG_LEN(SEG_LEN), .SEG_CNT(SEG_CNT)) u_ch_a (
    .clk (clk_a), .clr (clr_a), .wen (wen_a), .sin (sin_a),
    .tap_in (tap_in_a), .tap_out (tap_out_a), .tap_oe (tap_oe_a)
  );

  seg_tap_channel #(.SEG_LEN(SEG_LEN), .SEG_CNT(SEG_CNT)) u_ch_b (
    .clk (clk_b), .clr (clr_b), .wen (wen_b), .sin (sin_b),
    .tap_in (tap_in_b), .tap_out (tap_out_b), .tap_oe (tap_oe_b)
  );
endmodule

// File: rtl/seg_tap_channel_chk.sv
`timescale 1ns/1ps
module seg_tap_channel_chk #(
  parameter int unsigned SEG_LEN = seg_tap_pkg::SEG_LEN_DEF,
  parameter int unsigned SEG_CNT = seg_tap_pkg::SEG_CNT_DEF
) (
  input logic                            clk,
  input logic                            clr,
  input logic                            wen,
  input logic                            sin,
  input logic [SEG_CNT-2:0]              tap_in,
  input logic [SEG_CNT-1:0]              tap_oe,
  input logic [SEG_CNT-1:0][SEG_LEN-1:0] seg_q
);
  AST_SIN_ENTERS: assert property (@(posedge clk) disable iff (clr)
    !clr |=> seg_q[0][0] == $past(sin)); // R1

  AST_OE_OFF_WRITING: assert property (@(posedge clk) disable iff (clr)
    wen |-> tap_oe == '0); // R4

  AST_OE_ON_SHIFTING: assert property (@(posedge clk) disable iff (clr)
    !wen |-> &tap_oe); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    clr |=> seg_q == '0); // R7

  for (genvar k = 0; k < SEG_CNT; k++) begin : g_k
    AST_SEG_SHIFT: assert property (@(posedge clk) disable iff (clr)
      !clr |=> seg_q[k][SEG_LEN-1:1] == $past(seg_q[k][SEG_LEN-2:0])); // R2
    if (k > 0) begin : g_link
      AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (clr)
        !wen |=> seg_q[k][0] == $past(seg_q[k-1][SEG_LEN-1])); // R2
      AST_TAP_LOAD: assert property (@(posedge clk) disable iff (clr)
        wen |=> seg_q[k][0] == $past(tap_in[k-1])); // R3
    end
  end
endmodule

bind seg_tap_channel seg_tap_channel_chk #(.SEG_LEN(SEG_LEN), .SEG_CNT(SEG_CNT)) u_chk (
  .clk (clk), .clr (clr), .wen (wen), .sin (sin),
  .tap_in (tap_in), .tap_oe (tap_oe), .seg_q (seg_q)
);

// File: tb/test_seg_tap_shreg_dual.sv
`timescale 1ns/1ps
module test_seg_tap_shreg_dual;
  logic clk = 1'b0;
  logic run_a = 1'b1, run_b = 1'b1;
  logic clk_a, clk_b;
  logic clr_a = 1'b1, wen_a = 1'b0, sin_a = 1'b0;
  logic clr_b = 1'b1, wen_b = 1'b0, sin_b = 1'b0;
  logic [2:0] tap_in_a = '0, tap_in_b = '0;
  logic [3:0] tap_out_a, tap_oe_a, tap_out_b, tap_oe_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit val_a = 1'b0, val_b = 1'b0;
  logic [63:0] ma, mb; // index 0 = stage 1

  always #10 clk = ~clk;
  assign clk_a = clk & run_a;
  assign clk_b = clk & run_b;

  seg_tap_shreg_dual i_seg_tap_shreg_dual (
    .clk_a(clk_a), .clr_a(clr_a), .wen_a(wen_a), .sin_a(sin_a),
    .tap_in_a(tap_in_a), .tap_out_a(tap_out_a), .tap_oe_a(tap_oe_a),
    .clk_b(clk_b), .clr_b(clr_b), .wen_b(wen_b), .sin_b(sin_b),
    .tap_in_b(tap_in_b), .tap_out_b(tap_out_b), .tap_oe_b(tap_oe_b)
  );

  function automatic logic [63:0] model_step(logic [63:0] m, logic c, logic w,
                                             logic s, logic [2:0] t);
    logic [63:0] n;
    if (c) return '0;
    n[0] = s;
    for (int i = 1; i < 64; i++) begin
      if (w && (i % 16 == 0)) n[i] = t[i/16 - 1];
      else                    n[i] = m[i-1];
    end
    return n;
  endfunction

  always @(posedge clk_a) begin
    ma <= model_step(ma, clr_a, wen_a, sin_a, tap_in_a);
    if (clr_a) val_a <= 1'b1;
  end
  always @(posedge clk_b) begin
    mb <= model_step(mb, clr_b, wen_b, sin_b, tap_in_b);
    if (clr_b) val_b <= 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] taps_of(logic [63:0] m);
    return {m[63], m[47], m[31], m[15]};
  endfunction

  // per-clock comparison against the model, away from the active edge
  always begin
    @(negedge clk);
    #5;
    if (val_a) begin
      check(wen_a ? "R3/R5 tap values A" : "R2 tap values A",
            {28'd0, tap_out_a}, {28'd0, taps_of(ma)});
      check("R4 oe A", {28'd0, tap_oe_a}, {28'd0, {4{~wen_a}}});
    end
    if (val_b) begin
      check(run_b ? "R1/R2 tap values B" : "R8 idle B",
            {28'd0, tap_out_b}, {28'd0, taps_of(mb)});
      check("R4 oe B", {28'd0, tap_oe_b}, {28'd0, {4{~wen_b}}});
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] p0, p1, p2, p3, sq;
    logic [3:0]  snap_b;
    logic        expb;
    p0 = 16'hC3A5; p1 = 16'h1E0F; p2 = 16'h9B64; p3 = 16'h7D12; sq = 16'h5AF0;

    repeat (2) @(negedge clk);
    clr_a = 1'b0; clr_b = 1'b0;
    #6;
    check("R7 clear A", {28'd0, tap_out_a}, 32'd0);
    check("R7 clear B", {28'd0, tap_out_b}, 32'd0);
    @(negedge clk);

    // R6: parallel load on A in 16 clocks, four streams at once
    for (int i = 0; i < 16; i++) begin
      wen_a = 1'b1; sin_a = p0[i]; tap_in_a = {p3[i], p2[i], p1[i]};
      #6;
      check("R5 last tap disabled", {31'd0, tap_oe_a[3]}, 32'd0);
      @(negedge clk);
    end

    // serial read-back while channel B is idle (R8)
    run_b = 1'b0;
    snap_b = tap_out_b;
    for (int j = 0; j < 64; j++) begin
      wen_a = 1'b0; sin_a = sq[j % 16]; tap_in_a = 3'($urandom);
      sin_b = 1'($urandom); wen_b = 1'($urandom); tap_in_b = 3'($urandom);
      #6;
      if (j < 16)      expb = p3[j];
      else if (j < 32) expb = p2[j-16];
      else if (j < 48) expb = p1[j-32];
      else             expb = p0[j-48];
      check("R6 read-back order", {31'd0, tap_out_a[3]}, {31'd0, expb});
      check("R8 B frozen", {28'd0, tap_out_b}, {28'd0, snap_b});
      @(negedge clk);
    end
    run_b = 1'b1; wen_b = 1'b0;
    @(negedge clk);

    // random mixture of shifting and tap loading on both channels
    for (int c = 0; c < 400; c++) begin
      wen_a = 1'($urandom); sin_a = 1'($urandom); tap_in_a = 3'($urandom);
      wen_b = 1'($urandom); sin_b = 1'($urandom); tap_in_b = 3'($urandom);
      @(negedge clk);
    end

    // R7: clear in the middle of traffic
    clr_a = 1'b1; wen_a = 1'b1;
    @(negedge clk);
    clr_a = 1'b0; wen_a = 1'b0; sin_a = 1'b0;
    #6;
    check("R7 mid-run clear", {28'd0, tap_out_a}, 32'd0);
    @(negedge clk);

    // R1: serial input reaches tap 0 after 16 edges with write enable high
    for (int i = 0; i < 16; i++) begin
      wen_a = 1'b1; sin_a = sq[i]; tap_in_a = '0;
      @(negedge clk);
    end
    wen_a = 1'b0;
    #6;
    check("R1 stage16 holds first serial bit", {31'd0, tap_out_a[0]}, {31'd0, sq[0]});
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule